// File: doc/BRIEF.md
# Receive Frame Event Register

This block records the outcome of each received Ethernet frame in a 16-bit event word that a host can read. When the receive MAC signals end of frame, it supplies the frame's byte count together with the results of the CRC check, the address filters and the hash filter. In the same clock edge the block classifies the frame as good, runt, oversized or CRC-failed, and masks the address-match indications with the receive acceptance controls. It then writes the result into two registers. The event register is cleared when the host reads it. The status copy keeps its value until the next frame arrives.

When a frame is both good and accepted by the hash filter, the top six bits of the word hold the frame's 6-bit hash table index in place of the individual event flags. A length register keeps the byte count of the latest frame, limited to the largest legal frame size. An interrupt output stays high from an enabled event until the host reads the event register.

Top module: `rx_event_reg`

## Requirements
- R1: After a synchronous active-low reset, the event word and the status word both read 0x0004, the frame length reads 0 and the interrupt is low.
- R2: Bits 5..0 of the event word and of the status word always read 000100 (bit 2 set, all others clear).
- R3: Bit 8 (good frame) is set exactly when the CRC passed and the byte count lies in 64..1518 inclusive.
- R4: Outside hash-index mode, bit 12 is set on a CRC failure, bit 13 is set when the count is below 64, bit 14 is set when the count exceeds 1518, and bit 15 is 0.
- R5: Bit 7 is a copy of the trailing-partial-byte flag. When bit 7 and bit 12 are both set, the frame had an alignment error.
- R6: Bit 9 copies the hash-filter hit. When bits 8 and 9 are both set, bits 15..10 carry the 6-bit hash index, with index bit 0 in word bit 10.
- R7: Bit 6 is set exactly when the hash filter hit and the hash-accept control is on.
- R8: Outside hash-index mode, bit 10 is set exactly when the frame is good, the station address matched and the individual-accept control is on. Bit 11 is set exactly when the frame is good, the destination is broadcast and the broadcast-accept control is on.
- R9: A host read with no frame capture in the same cycle returns the event word to 0x0004 at the next edge and leaves the status word unchanged.
- R10: When a frame capture and a host read fall in the same cycle, the new frame's word is kept in the event register.
- R11: Each capture loads the frame length register with the byte count, capped at 1518.
- R12: Every capture sets the interrupt when one of these holds: good frame with its enable on, CRC error with its enable on, runt with its enable on, or oversize with its enable on. The interrupt then stays high until a host read in a cycle without an interrupting capture.
- R13: Each capture overwrites both the event word and the status word with the new frame's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eof_valid | input | 1 | One-cycle end-of-frame strobe |
| eof_len | input | 16 | Received byte count |
| eof_crc_ok | input | 1 | CRC check passed |
| eof_dribble | input | 1 | One to seven bits after the last whole byte |
| eof_hash_hit | input | 1 | Hash filter accepted the destination |
| eof_hash_idx | input | 6 | Hash table index of the destination |
| eof_ia_match | input | 1 | Destination equals the station address |
| eof_bcast_match | input | 1 | Destination is all ones |
| ctl_hash_acc | input | 1 | Hash-accept control |
| ctl_ia_acc | input | 1 | Individual-accept control |
| ctl_bcast_acc | input | 1 | Broadcast-accept control |
| ie_good | input | 1 | Interrupt enable for good frames |
| ie_crc | input | 1 | Interrupt enable for CRC errors |
| ie_runt | input | 1 | Interrupt enable for runt frames |
| ie_extra | input | 1 | Interrupt enable for oversized frames |
| evt_rd | input | 1 | Host read strobe of the event word |
| evt_word | output | 16 | Clear-on-read event word |
| stat_word | output | 16 | Non-clearing status copy |
| frame_len | output | 16 | Length of the latest frame |
| irq | output | 1 | Level interrupt |

## Verification
Every result of this block is due exactly one rising edge after the cycle that holds the strobe: the event word, status word, length and interrupt after an end-of-frame strobe, and the cleared event word and dropped interrupt after a read strobe. The bench drives inputs after a falling edge. At the next rising edge it advances a behavioural model using those same inputs, and it compares all four outputs at the following falling edge. This way each comparison sees the registers one edge after the stimulus, with no race at the active edge.

// File: rtl/rxev_pkg.sv
// Package: shared constants and the frame classification record used by the
// receive event register. Assumes a 16-bit event word with a 6-bit hash index.
package rxev_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = 6;

    // Fixed identifier that occupies the low six bits of every word.
    localparam logic [5:0] ID_PAT = 6'b000100;
    localparam logic [WORD_W-1:0] RESET_WORD = {{(WORD_W-6){1'b0}}, ID_PAT};

    // Bit positions decoded by host software.
    localparam int B_IAHASH  = 6;
    localparam int B_DRIBBLE = 7;
    localparam int B_GOOD    = 8;
    localparam int B_HASHED  = 9;
    localparam int B_IA      = 10;
    localparam int B_BCAST   = 11;
    localparam int B_CRCERR  = 12;
    localparam int B_RUNT    = 13;
    localparam int B_EXTRA   = 14;
    localparam int IDX_LO    = 10;

    // Classification of one received frame.
    typedef struct packed {
        logic good;
        logic crc_err;
        logic runt;
        logic extra;
        logic dribble;
        logic hashed;
        logic ia_hash;
        logic ia_ok;
        logic bc_ok;
    } frame_flags_t;

endpackage

// File: rtl/rxev_classify.sv
// Module: classifies a finished frame from its byte count and filter results,
// and caps the reported length. Purely combinational; assumes its inputs are
// valid in the cycle the end-of-frame strobe is high.
module rxev_classify
    import rxev_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic [LEN_W-1:0] len,
    input  logic             crc_ok,
    input  logic             dribble,
    input  logic             hash_hit,
    input  logic             ia_match,
    input  logic             bcast_match,
    input  logic             ctl_hash_acc,
    input  logic             ctl_ia_acc,
    input  logic             ctl_bcast_acc,
    output frame_flags_t     flags,
    output logic [LEN_W-1:0] len_capped
);

    localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_V = LEN_W'(MAX_LEN);

    logic too_short;
    logic too_long;

    // Length range comparisons.
    always_comb begin
        too_short = (len < MIN_V);
        too_long  = (len > MAX_V);
    end

    // Frame flags, with the address matches qualified by goodness and controls.
    always_comb begin
        flags.crc_err = ~crc_ok;
        flags.runt    = too_short;
        flags.extra   = too_long;
        flags.good    = crc_ok & ~too_short & ~too_long;
        flags.dribble = dribble;
        flags.hashed  = hash_hit;
        flags.ia_hash = hash_hit & ctl_hash_acc;
        flags.ia_ok   = ia_match & crc_ok & ~too_short & ~too_long & ctl_ia_acc;
        flags.bc_ok   = bcast_match & crc_ok & ~too_short & ~too_long & ctl_bcast_acc;
    end

    // Bytes past the maximum are dropped, so the length saturates.
    always_comb begin
        len_capped = too_long ? MAX_V : len;
    end

endmodule

// File: rtl/rxev_compose.sv
// Module: packs frame flags and the hash index into the 16-bit event word.
// When a frame is both good and hashed, the upper field carries the index.
// Purely combinational.
module rxev_compose
    import rxev_pkg::*;
(
    input  frame_flags_t      flags,
    input  logic [IDX_W-1:0]  hash_idx,
    output logic [WORD_W-1:0] word
);

    logic idx_mode;

    // Selects the meaning of the upper six bits.
    always_comb idx_mode = flags.hashed & flags.good;

    // Word assembly.
    always_comb begin
        word            = '0;
        word[5:0]       = ID_PAT;
        word[B_IAHASH]  = flags.ia_hash;
        word[B_DRIBBLE] = flags.dribble;
        word[B_GOOD]    = flags.good;
        word[B_HASHED]  = flags.hashed;
        if (idx_mode) begin
            word[IDX_LO +: IDX_W] = hash_idx;
        end else begin
            word[B_IA]     = flags.ia_ok;
            word[B_BCAST]  = flags.bc_ok;
            word[B_CRCERR] = flags.crc_err;
            word[B_RUNT]   = flags.runt;
            word[B_EXTRA]  = flags.extra;
        end
    end

endmodule

// File: rtl/rxev_irq.sv
// Module: level interrupt. Set by a capture that carries an enabled cause,
// cleared by a host read of the event word. A capture in the same cycle as a
// read decides the new level. Synchronous active-low reset.
module rxev_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic cause,
    input  logic clear,
    output logic irq
);

    // Interrupt level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= (capture & cause) | (irq & ~clear);
        end
    end

    // R12: a pending interrupt with no read stays high.
    a_r12_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clear) |=> irq);

    // R12: a read with no interrupting capture drops the interrupt.
    a_r12_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !(capture && cause)) |=> !irq);

endmodule

// File: rtl/rx_event_reg.sv
// Module: top of the receive event register. Holds the clear-on-read event
// word, the status copy and the capped frame length, and drives the interrupt.
// Assumes eof_valid is a single-cycle strobe with its attributes valid alongside.
module rx_event_reg
    import rxev_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eof_valid,
    input  logic [LEN_W-1:0] eof_len,
    input  logic             eof_crc_ok,
    input  logic             eof_dribble,
    input  logic             eof_hash_hit,
    input  logic [5:0]       eof_hash_idx,
    input  logic             eof_ia_match,
    input  logic             eof_bcast_match,
    input  logic             ctl_hash_acc,
    input  logic             ctl_ia_acc,
    input  logic             ctl_bcast_acc,
    input  logic             ie_good,
    input  logic             ie_crc,
    input  logic             ie_runt,
    input  logic             ie_extra,
    input  logic             evt_rd,
    output logic [15:0]      evt_word,
    output logic [15:0]      stat_word,
    output logic [LEN_W-1:0] frame_len,
    output logic             irq
);

    frame_flags_t      flags;
    logic [LEN_W-1:0]  len_capped;
    logic [WORD_W-1:0] new_word;
    logic              irq_cause;

    rxev_classify #(
        .LEN_W  (LEN_W),
        .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN)
    ) u_classify (
        .len          (eof_len),
        .crc_ok       (eof_crc_ok),
        .dribble      (eof_dribble),
        .hash_hit     (eof_hash_hit),
        .ia_match     (eof_ia_match),
        .bcast_match  (eof_bcast_match),
        .ctl_hash_acc (ctl_hash_acc),
        .ctl_ia_acc   (ctl_ia_acc),
        .ctl_bcast_acc(ctl_bcast_acc),
        .flags        (flags),
        .len_capped   (len_capped)
    );

    rxev_compose u_compose (
        .flags   (flags),
        .hash_idx(eof_hash_idx),
        .word    (new_word)
    );

    // Interrupt cause from raw classification, independent of the index overlay.
    always_comb begin
        irq_cause = (flags.good & ie_good) | (flags.crc_err & ie_crc) |
                    (flags.runt & ie_runt) | (flags.extra & ie_extra);
    end

    rxev_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(eof_valid),
        .cause  (irq_cause),
        .clear  (evt_rd),
        .irq    (irq)
    );

    // Event word: capture wins over a simultaneous read; a lone read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_word <= RESET_WORD;
        end else if (eof_valid) begin
            evt_word <= new_word;
        end else if (evt_rd) begin
            evt_word <= RESET_WORD;
        end
    end

    // Status copy: follows captures only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_word <= RESET_WORD;
        end else if (eof_valid) begin
            stat_word <= new_word;
        end
    end

    // Frame length register: loads the capped count on every capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_len <= '0;
        end else if (eof_valid) begin
            frame_len <= len_capped;
        end
    end

    // R9: a lone read returns the event word to its idle value.
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd && !eof_valid) |=> (evt_word == 16'h0004));

    // R9: the status copy ignores reads.
    a_r9_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!eof_valid) |=> $stable(stat_word));

    // R10, R13: after a capture both words agree, even with a read alongside.
    a_r13_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
        eof_valid |=> (evt_word == stat_word));

    // R11: the reported length never exceeds the maximum frame size.
    a_r11_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
        eof_valid |=> (frame_len <= LEN_W'(MAX_LEN)));

    // R3: a good frame was captured only from an in-range count.
    a_r3_good_range: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_valid && (eof_len < LEN_W'(MIN_LEN))) |=> !evt_word[B_GOOD]);

endmodule

// File: tb/test_rx_event_reg.sv
// Bench: behavioural reference model updated at each rising edge and compared
// with every output at the following falling edge.
module test_rx_event_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eof_valid = 1'b0;
    logic [15:0] eof_len = '0;
    logic        eof_crc_ok = 1'b0, eof_dribble = 1'b0, eof_hash_hit = 1'b0;
    logic [5:0]  eof_hash_idx = '0;
    logic        eof_ia_match = 1'b0, eof_bcast_match = 1'b0;
    logic        ctl_hash_acc = 1'b0, ctl_ia_acc = 1'b0, ctl_bcast_acc = 1'b0;
    logic        ie_good = 1'b0, ie_crc = 1'b0, ie_runt = 1'b0, ie_extra = 1'b0;
    logic        evt_rd = 1'b0;
    logic [15:0] evt_word, stat_word, frame_len;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int m_evt = 4, m_stat = 4, m_len = 0, m_irq = 0;

    always #5 clk = ~clk;

    rx_event_reg i_rx_event_reg (
        .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .eof_len(eof_len),
        .eof_crc_ok(eof_crc_ok), .eof_dribble(eof_dribble),
        .eof_hash_hit(eof_hash_hit), .eof_hash_idx(eof_hash_idx),
        .eof_ia_match(eof_ia_match), .eof_bcast_match(eof_bcast_match),
        .ctl_hash_acc(ctl_hash_acc), .ctl_ia_acc(ctl_ia_acc),
        .ctl_bcast_acc(ctl_bcast_acc), .ie_good(ie_good), .ie_crc(ie_crc),
        .ie_runt(ie_runt), .ie_extra(ie_extra), .evt_rd(evt_rd),
        .evt_word(evt_word), .stat_word(stat_word), .frame_len(frame_len),
        .irq(irq)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
        end
    endtask

    // Reference word built arithmetically from the requirements.
    function automatic int ref_word();
        int  w = 4;
        int  n = int'(eof_len);
        bit  good = eof_crc_ok && n >= 64 && n <= 1518;
        if (eof_hash_hit && ctl_hash_acc) w += 64;      // R7
        if (eof_dribble) w += 128;                       // R5
        if (good) w += 256;                              // R3
        if (eof_hash_hit) w += 512;                      // R6
        if (eof_hash_hit && good) w += int'(eof_hash_idx) * 1024;
        else begin
            if (good && eof_ia_match && ctl_ia_acc) w += 1024;      // R8
            if (good && eof_bcast_match && ctl_bcast_acc) w += 2048;
            if (!eof_crc_ok) w += 4096;                  // R4
            if (n < 64) w += 8192;
            if (n > 1518) w += 16384;
        end
        return w;
    endfunction

    function automatic int ref_cause();
        int n = int'(eof_len);
        bit good = eof_crc_ok && n >= 64 && n <= 1518;
        return int'((good && ie_good) || (!eof_crc_ok && ie_crc) ||
                    (n < 64 && ie_runt) || (n > 1518 && ie_extra));
    endfunction

    task automatic compare(input string tag);
        chk(tag, "evt_word", int'(evt_word), m_evt);
        chk(tag, "stat_word", int'(stat_word), m_stat);
        chk(tag, "frame_len", int'(frame_len), m_len);
        chk(tag, "irq", int'(irq), m_irq);
        chk("R2", "id bits", int'(evt_word[5:0]) * 64 + int'(stat_word[5:0]), 4 * 64 + 4);
    endtask

    // One clock: model advances at the rising edge, outputs compared after.
    task automatic tick(input string tag);
        @(posedge clk);
        if (eof_valid) begin
            m_evt  = ref_word();
            m_stat = m_evt;
            m_len  = (int'(eof_len) > 1518) ? 1518 : int'(eof_len);
            m_irq  = int'(ref_cause() != 0 || (m_irq != 0 && !evt_rd));
        end else if (evt_rd) begin
            m_evt = 4;
            m_irq = 0;
        end
        @(negedge clk);
        compare(tag);
        eof_valid = 1'b0;
        evt_rd    = 1'b0;
    endtask

    task automatic frame(input string tag, input int n, input bit crc, input bit drib,
                         input bit hh, input int idx, input bit ia, input bit bc, input bit rd);
        eof_len = 16'(n); eof_crc_ok = crc; eof_dribble = drib; eof_hash_hit = hh;
        eof_hash_idx = 6'(idx); eof_ia_match = ia; eof_bcast_match = bc;
        eof_valid = 1'b1; evt_rd = rd;
        tick(tag);
    endtask

    task automatic host_read(input string tag);
        evt_rd = 1'b1;
        tick(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        tick("R1 idle");

        ie_good = 1'b1;
        frame("R3 R11 R12 good 100", 100, 1, 0, 0, 0, 0, 0, 0);
        tick("R12 irq held");
        host_read("R9 R12 read clears");
        tick("R9 idle after read");

        ie_crc = 1'b1;
        frame("R4 R5 alignment", 200, 0, 1, 0, 0, 0, 0, 0);
        host_read("R9 read");
        ie_runt = 1'b1;
        frame("R4 runt 63", 63, 1, 0, 0, 0, 0, 0, 0);
        frame("R3 R13 edge 64", 64, 1, 0, 0, 0, 0, 0, 0);
        frame("R3 edge 1518", 1518, 1, 0, 0, 0, 0, 0, 0);
        host_read("R9 read");
        frame("R4 R11 R12 extra 1519 no enable", 1519, 1, 0, 0, 0, 0, 0, 0);
        ie_extra = 1'b1;
        frame("R4 R11 R12 extra 3000", 3000, 1, 0, 0, 0, 0, 0, 0);
        host_read("R12 read");

        ctl_hash_acc = 1'b1;
        frame("R6 R7 index 0x2A", 300, 1, 0, 1, 42, 1, 1, 0);
        frame("R6 index 0x3F", 1518, 1, 1, 1, 63, 0, 0, 0);
        frame("R6 hashed bad crc", 300, 0, 0, 1, 21, 0, 0, 0);
        ctl_hash_acc = 1'b0;
        frame("R7 hash no accept", 90, 1, 0, 1, 5, 0, 0, 0);

        frame("R8 ia without control", 80, 1, 0, 0, 0, 1, 0, 0);
        ctl_ia_acc = 1'b1;
        frame("R8 ia accepted", 80, 1, 0, 0, 0, 1, 0, 0);
        frame("R8 ia on bad frame", 80, 0, 0, 0, 0, 1, 0, 0);
        frame("R8 bcast without control", 80, 1, 0, 0, 0, 0, 1, 0);
        ctl_bcast_acc = 1'b1;
        frame("R8 bcast accepted", 80, 1, 0, 0, 0, 0, 1, 0);
        frame("R8 bcast runt", 40, 1, 0, 0, 0, 0, 1, 0);

        host_read("R9 read");
        ie_good = 1'b0; ie_crc = 1'b0; ie_runt = 1'b0; ie_extra = 1'b0;
        frame("R10 capture with read", 500, 1, 1, 0, 0, 1, 0, 1);
        ie_crc = 1'b1;
        frame("R10 R12 capture with read irq", 500, 0, 0, 0, 0, 0, 0, 1);
        frame("R13 overwrite", 700, 1, 0, 0, 0, 0, 1, 0);
        frame("R13 overwrite again", 65, 1, 0, 0, 0, 1, 0, 0);
        host_read("R9 final read");
        tick("R9 settle");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule